// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers one-cycle event pulses from eleven peripheral sources and holds them in three 4-bit request banks. Each bank has a companion 4-bit mask bank. A mask bit acts as a gate at capture time: a pulse arriving while its mask bit is 0 is discarded and leaves no trace. Software reaches the banks through a small register port with a combinational read path. A request bit is cleared by writing 1 to it.

A single interrupt line goes to the CPU. It is qualified by a global enable bit, which software can read and write. The enable also turns itself on when the CPU signals entry into halt, so that any pending or later request can wake the CPU. A hold input from an automatic sequencer blocks that self-enable, and while the hold is high it also keeps the interrupt line low.

Register map (3-bit address): 0, 1 and 2 are request banks A, B and C; 3, 4 and 5 are mask banks A, B and C; 6 is the control register, with the global enable in bit 0. Every other address, and every unlisted bit, reads 0.

Top module: `pulse_irq_ctrl`

## Requirements
- R1: A source pulse sets its request bit on the next clock edge when that source's mask bit is 1.
- R2: A source pulse arriving while its mask bit is 0 is dropped, and the request bit stays 0.
- R3: Request capture does not depend on the global enable; requests latch while the enable is 0.
- R4: After reset, every request bit, every mask bit and the global enable read 0.
- R5: Writing 1 to a request bit clears it. Writing 0 leaves the bit unchanged.
- R6: The mask registers read back the value last written to their implemented bits.
- R7: Bit mapping. Bank A bits 3..0 hold pin events 3..0. In bank B, bit 0 is conversion done, bit 1 is memory write done, bit 2 is the fast tick and bit 3 is the slow tick. In bank C, bit 0 is counter match, bit 1 is counter zero and bit 2 is level detect.
- R8: Bit 3 of request bank C and bit 3 of mask bank C are not implemented and always read 0.
- R9: A halt-entry strobe while the hold input is low sets the global enable to 1 on the next edge. This takes priority over a software write in the same cycle.
- R10: While the hold input is high, a halt-entry strobe leaves the global enable unchanged, and irq_o is held low.
- R11: irq_o is 1 exactly when the global enable is 1, the hold input is low and at least one request bit is set.
- R12: When a source pulse and a write-1-to-clear hit the same unmasked bit in the same cycle, the bit ends up set.
- R13: The global enable is readable and writable at bit 0 of address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_evt_i | input | 4 | Pin event pulses 3..0 |
| tick_slow_i | input | 1 | Slow prescaler tick pulse |
| tick_fast_i | input | 1 | Fast prescaler tick pulse |
| nvm_done_i | input | 1 | Memory write done pulse |
| conv_done_i | input | 1 | Conversion done pulse |
| lvl_det_i | input | 1 | Level detect pulse |
| cnt_zero_i | input | 1 | Counter reached zero pulse |
| cnt_match_i | input | 1 | Counter compare match pulse |
| halt_enter_i | input | 1 | Halt entry strobe |
| auto_hold_i | input | 1 | Automatic sequencer hold level |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Two pairs of actions can land in the same cycle.

The first pair is a new event pulse and a software write-1-to-clear on the same request bit. The bench drives both on one clock edge, then reads the bank back; the bit must still be set.

The second pair is a halt strobe and a software write of 0 to the enable. The bench applies both together and expects the enable to read 1.

A behavioural model, updated at each edge, judges these cases and checks irq_o on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 4;
  localparam int ADDR_W    = 3;
  localparam int TOTAL_W   = NUM_BANKS * BANK_W;
  localparam int REQ_BASE  = 0;
  localparam int MASK_BASE = NUM_BANKS;
  localparam int CTRL_ADDR = 2 * NUM_BANKS;
  // implemented request/mask bits, bank C bit 3 absent
  localparam logic [TOTAL_W-1:0] IMPL_BITS = 12'h7FF;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 4,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         req_wr_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] req_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] clr;

  assign clr = req_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= '0;
      mask_o <= '0;
    end else begin
      if (mask_wr_i) mask_o <= wdata_i & IMPL;
      // capture after clear: a fresh event survives a same-cycle clear
      req_o <= ((req_o & ~clr) | (evt_i & mask_o)) & IMPL;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic en_wdata_i,
  input  logic halt_enter_i,
  input  logic auto_hold_i,
  input  logic any_req_i,
  output logic gie_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_o <= 1'b0;
    end else begin
      if (ctrl_wr_i) gie_o <= en_wdata_i;
      if (halt_enter_i && !auto_hold_i) gie_o <= 1'b1;
    end
  end

  assign irq_o = gie_o & ~auto_hold_i & any_req_i;
endmodule

// File: rtl/pulse_irq_ctrl.sv
module pulse_irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        pin_evt_i,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              nvm_done_i,
  input  logic              conv_done_i,
  input  logic              lvl_det_i,
  input  logic              cnt_zero_i,
  input  logic              cnt_match_i,
  input  logic              halt_enter_i,
  input  logic              auto_hold_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BANK_W-1:0] reg_wdata_i,
  output logic [BANK_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [TOTAL_W-1:0] evt_vec;
  logic [TOTAL_W-1:0] req_q;
  logic [TOTAL_W-1:0] mask_q;
  logic               gie_q;
  logic               ctrl_wr;

  assign evt_vec = {1'b0, lvl_det_i, cnt_zero_i, cnt_match_i,
                    tick_slow_i, tick_fast_i, nvm_done_i, conv_done_i,
                    pin_evt_i};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic req_wr, mask_wr;
    assign req_wr  = reg_we_i && (reg_addr_i == ADDR_W'(REQ_BASE + b));
    assign mask_wr = reg_we_i && (reg_addr_i == ADDR_W'(MASK_BASE + b));

    irq_bank #(
      .W    (BANK_W),
      .IMPL (IMPL_BITS[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_vec[b*BANK_W +: BANK_W]),
      .req_wr_i  (req_wr),
      .mask_wr_i (mask_wr),
      .wdata_i   (reg_wdata_i),
      .req_o     (req_q[b*BANK_W +: BANK_W]),
      .mask_o    (mask_q[b*BANK_W +: BANK_W])
    );
  end

  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_ADDR));

  irq_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (ctrl_wr),
    .en_wdata_i   (reg_wdata_i[0]),
    .halt_enter_i (halt_enter_i),
    .auto_hold_i  (auto_hold_i),
    .any_req_i    (|req_q),
    .gie_o        (gie_q),
    .irq_o        (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr_i == ADDR_W'(REQ_BASE + b))  reg_rdata_o = req_q[b*BANK_W +: BANK_W];
      if (reg_addr_i == ADDR_W'(MASK_BASE + b)) reg_rdata_o = mask_q[b*BANK_W +: BANK_W];
    end
    if (reg_addr_i == ADDR_W'(CTRL_ADDR)) reg_rdata_o = {{(BANK_W-1){1'b0}}, gie_q};
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [TOTAL_W-1:0] evt_vec,
  input logic [TOTAL_W-1:0] req_q,
  input logic [TOTAL_W-1:0] mask_q,
  input logic               gie_q,
  input logic               halt_enter_i,
  input logic               auto_hold_i,
  input logic               irq_o
);
  // R1 R2: a request bit rises only from an unmasked event
  a_r2_masked_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q & ~$past(req_q) & ~($past(evt_vec) & $past(mask_q))) == '0);

  // R1 R12: an unmasked event always leaves its bit set
  a_r12_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(evt_vec) & $past(mask_q) & IMPL_BITS) & ~req_q) == '0);

  // R8
  a_r8_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_q | mask_q) & ~IMPL_BITS) == '0);

  // R9
  a_r9_halt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_enter_i && !auto_hold_i) |=> gie_q);

  // R10
  a_r10_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_hold_i |-> !irq_o);

  // R11
  a_r11_irq_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (gie_q && !auto_hold_i && (req_q != '0)));
endmodule

bind pulse_irq_ctrl irq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_vec      (evt_vec),
  .req_q        (req_q),
  .mask_q       (mask_q),
  .gie_q        (gie_q),
  .halt_enter_i (halt_enter_i),
  .auto_hold_i  (auto_hold_i),
  .irq_o        (irq_o)
);

// File: tb/sim_pulse_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pulse_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pin_evt_i = '0;
  logic       tick_slow_i = 0, tick_fast_i = 0, nvm_done_i = 0, conv_done_i = 0;
  logic       lvl_det_i = 0, cnt_zero_i = 0, cnt_match_i = 0;
  logic       halt_enter_i = 0, auto_hold_i = 0, reg_we_i = 0;
  logic [2:0] reg_addr_i = '0;
  logic [3:0] reg_wdata_i = '0;
  logic [3:0] reg_rdata_o;
  logic       irq_o;

  int n_run = 0, n_fail = 0;

  // reference state
  bit [11:0] m_req, m_mask;
  bit        m_gie;

  always #4 clk_i = ~clk_i;

  pulse_irq_ctrl u0 (.*);

  function automatic bit [3:0] model_rd(int a);
    if (a < 3)  return m_req[a*4 +: 4];
    if (a < 6)  return m_mask[(a-3)*4 +: 4];
    if (a == 6) return {3'b0, m_gie};
    return 4'h0;
  endfunction

  function automatic bit [11:0] evt_now();
    return {1'b0, lvl_det_i, cnt_zero_i, cnt_match_i, tick_slow_i, tick_fast_i,
            nvm_done_i, conv_done_i, pin_evt_i};
  endfunction

  task automatic set_evt(bit [11:0] v);
    pin_evt_i = v[3:0];
    conv_done_i = v[4]; nvm_done_i = v[5]; tick_fast_i = v[6]; tick_slow_i = v[7];
    cnt_match_i = v[8]; cnt_zero_i = v[9]; lvl_det_i = v[10];
  endtask

  // one clock: model advances on the edge, irq_o compared after it
  task automatic cyc();
    bit [11:0] nreq, ev;
    bit        ngie;
    @(posedge clk_i);
    ev = evt_now();
    nreq = m_req;
    ngie = m_gie;
    if (reg_we_i && reg_addr_i < 3) nreq &= ~(12'(reg_wdata_i) << (4*reg_addr_i));
    nreq = (nreq | (ev & m_mask)) & 12'h7FF;
    if (reg_we_i && reg_addr_i >= 3 && reg_addr_i < 6)
      m_mask[(reg_addr_i-3)*4 +: 4] = reg_wdata_i;
    m_mask &= 12'h7FF;
    if (reg_we_i && reg_addr_i == 6) ngie = reg_wdata_i[0];
    if (halt_enter_i && !auto_hold_i) ngie = 1'b1;
    m_req = nreq;
    m_gie = ngie;
    #2;
    n_run++;
    if (irq_o !== (m_gie && !auto_hold_i && m_req != 0)) begin
      n_fail++;
      $display("FAIL R11 irq_o got %0b exp %0b", irq_o, (m_gie && !auto_hold_i && m_req != 0));
    end
  endtask

  task automatic wr(int a, bit [3:0] d);
    reg_we_i = 1; reg_addr_i = 3'(a); reg_wdata_i = d;
    cyc();
    reg_we_i = 0;
  endtask

  task automatic pulse(bit [11:0] v);
    set_evt(v);
    cyc();
    set_evt('0);
  endtask

  task automatic rd(int a, string tag);
    reg_addr_i = 3'(a);
    #1;
    n_run++;
    if (reg_rdata_o !== model_rd(a)) begin
      n_fail++;
      $display("FAIL %s addr %0d got %h exp %h", tag, a, reg_rdata_o, model_rd(a));
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_req = '0; m_mask = '0; m_gie = 0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    for (int a = 0; a < 8; a++) rd(a, "R4 reset");

    // R2: all sources pulse with every mask at 0
    pulse(12'h7FF);
    for (int a = 0; a < 3; a++) rd(a, "R2 masked drop");

    // R6 R8: open all masks, bank C bit 3 stays 0
    wr(3, 4'hF); wr(4, 4'hF); wr(5, 4'hF);
    for (int a = 3; a < 6; a++) rd(a, "R6 R8 mask readback");

    // R1 R3: capture while global enable is 0
    pulse(12'h005);
    rd(0, "R1 R3 capture with enable low");
    rd(6, "R13 enable still 0");

    // R7: each source on its own, then cleared
    for (int i = 0; i < 11; i++) begin
      pulse(12'(1) << i);
      rd(i / 4, "R7 bit mapping");
      wr(i / 4, 4'(1 << (i % 4)));
      rd(i / 4, "R5 clear after map");
    end
    rd(2, "R8 bank C bit3");

    // R5: write 0 keeps, write 1 clears
    pulse(12'h0F0);
    wr(1, 4'h0);
    rd(1, "R5 write zero keeps");
    wr(1, 4'h6);
    rd(1, "R5 partial clear");

    // R13 R11: enable by software, irq follows
    wr(6, 4'h1);
    rd(6, "R13 enable write");
    wr(1, 4'hF);
    rd(1, "R11 cleared, irq low");

    // R12: same-cycle event and clear on bank A bit 2
    pulse(12'h004);
    reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 4'h4; set_evt(12'h004);
    cyc();
    reg_we_i = 0; set_evt('0);
    rd(0, "R12 event wins over clear");
    wr(0, 4'hF);
    rd(0, "R5 cleared");

    // R9: halt with software write of 0 in the same cycle
    wr(6, 4'h0);
    reg_we_i = 1; reg_addr_i = 6; reg_wdata_i = 4'h0; halt_enter_i = 1;
    cyc();
    reg_we_i = 0; halt_enter_i = 0;
    rd(6, "R9 halt sets enable");

    // R10: hold blocks auto-set and masks irq
    wr(6, 4'h0);
    auto_hold_i = 1;
    halt_enter_i = 1; cyc(); halt_enter_i = 0;
    rd(6, "R10 halt under hold");
    wr(6, 4'h1);
    pulse(12'h100);
    rd(2, "R10 request pending under hold");
    cyc();
    auto_hold_i = 0;
    cyc();
    rd(2, "R11 pending after hold release");

    // R6 R2: partial mask, masked-off bits dropped
    wr(2, 4'hF);
    wr(3, 4'h9);
    rd(3, "R6 partial mask");
    pulse(12'h00F);
    rd(0, "R2 partial mask drop");
    wr(5, 4'h0);
    pulse(12'h700);
    rd(2, "R2 bank C masked");

    repeat (3) cyc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule